// File: doc/BRIEF.md
# Linear CCD Readout Timing Controller

This block drives a 2048-pixel linear CCD sensor that carries its own clock drivers. It works from a faster system clock. It produces the sensor's pixel clock at 50% duty from a programmable half-period. Before each line it issues a transfer-gate pulse, then waits a guard interval before the clock restarts. It counts the pixel clock pulses of every line and sorts each output period into one of five classes: leading dummy, optical black, effective, trailing dummy, or none once the line's output has ended.

A downstream converter receives three things from the block. The first is a sample strobe placed on the last system cycle of each pixel period, so that the analog output has settled. The second is a valid flag and a 0-based pixel index for the effective pixels. The third is a pair of single-cycle markers for the start and end of each line. The line period in pixel clocks sets the integration time.

The half-period, gate width, guard gap, line period and sample-and-hold selection are run-time inputs. The block takes a copy of them when each line starts and raises any value below its legal minimum to that minimum. After reset, the valid and optical-black flags stay low until 22500 pixel clock pulses have been issued, which gives the sensor time to warm up. All outputs are synchronous to the system clock.

Top module: `ccd_line_timer`

## Requirements
- R1: `ccd_clk` is high for exactly H and then low for exactly H system cycles in every pixel period, with H = max(`cfg_half`, MIN_HALF). MIN_HALF is the smallest half-period that keeps the pixel clock at or below 2 MHz (1 at the default 250 ns system period).
- R2: Each line carries exactly max(`cfg_line`, 2088) rising edges of `ccd_clk`, and then the next gate pulse follows.
- R3: `ccd_gate` stays high for exactly max(`cfg_gate`, MIN_GATE) cycles, where MIN_GATE corresponds to 3000 ns (12 at default). `ccd_clk` stays low for the whole pulse. `line_start` pulses for one cycle, on the first cycle of the gate.
- R4: After `ccd_gate` falls, `ccd_clk` stays low for exactly max(`cfg_gap`, MIN_GAP) cycles before it rises, where MIN_GAP corresponds to 1000 ns (4 at default).
- R5: The configuration inputs are taken only on the cycle before a gate pulse starts. A change made while a line is running affects only the following line.
- R6: With `cfg_sh`=0, the pixel started by the n-th clock edge of a line has the class given by `pix_class`: n in 1..32 is leading (code 1, or code 2 when it is optical black), n in 33..2080 is effective (code 3), n in 2081..2086 is trailing (code 4), and anything else is code 0.
- R7: With `cfg_sh`=1, there are 33 leading pixels, so every boundary of R6 moves one edge later. `ccd_shsel` shows the selection that the current line uses.
- R8: Exactly 18 pixels per line are optical black, at edges 13..30 (or 14..31 with `cfg_sh`=1). After warm-up, `ob_flag` marks these pixels and is never high together with `pix_valid`.
- R9: After warm-up, `pix_valid` is high exactly during effective pixels. During those pixels `pix_idx` runs 0..2047 in order, with `pix_idx` = n − L − 1, where L is the count of leading pixels.
- R10: `adc_strobe` pulses once per pixel period, on the last system cycle of the low half of `ccd_clk`.
- R11: `line_end` pulses for one cycle per line, together with the strobe of the last trailing pixel (edge 2086, or 2087 with `cfg_sh`=1).
- R12: `pix_valid` and `ob_flag` stay low until at least 22500 rising edges of `ccd_clk` have been issued since reset.
- R13: While reset is asserted, `ccd_clk`, `ccd_gate`, `adc_strobe`, `pix_valid`, `line_start` and `line_end` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_half | input | HALF_W | Pixel clock half-period in system cycles |
| cfg_gate | input | TIME_W | Gate pulse width in system cycles |
| cfg_gap | input | TIME_W | Gate-fall to first clock edge gap in system cycles |
| cfg_line | input | LINE_W | Line period in pixel clocks |
| cfg_sh | input | 1 | 1 selects sample-and-hold line structure |
| ccd_clk | output | 1 | Pixel clock to the sensor |
| ccd_gate | output | 1 | Transfer-gate pulse to the sensor |
| ccd_shsel | output | 1 | Sample-and-hold selection applied to the current line |
| adc_strobe | output | 1 | Converter sample strobe, one per pixel |
| pix_class | output | 3 | Class of the current pixel (codes per R6) |
| pix_valid | output | 1 | Effective pixel after warm-up |
| pix_idx | output | IDX_W | Effective pixel index, 0 when not effective |
| ob_flag | output | 1 | Optical-black pixel after warm-up |
| line_start | output | 1 | One-cycle pulse at gate start |
| line_end | output | 1 | One-cycle pulse at the last trailing pixel's strobe |

## Verification
The assertions assume that the configuration inputs hold their values for at least one cycle around the capture point. They also assume that each configured value fits its port width, and that the default system period makes the derived minima at least one cycle. The stimulus changes configuration only on the falling edge of the system clock, on the cycle where `line_start` is seen. Because capture happened one edge earlier, the running line keeps its old settings. The stimulus also covers the clamping path, by driving values below every minimum, including zeros.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;

  localparam int EFF_PIX        = 2048;
  localparam int LEAD_BASE      = 32;
  localparam int TRAIL_PIX      = 6;
  localparam int OB_FIRST       = 13;
  localparam int OB_LAST        = 30;
  localparam int LINE_FLOOR     = 2088;
  localparam int IDX_W          = $clog2(EFF_PIX);
  localparam int CLK_PERIOD_MIN = 500;
  localparam int GATE_MIN_NS    = 3000;
  localparam int GAP_MIN_NS     = 1000;

  typedef enum logic [2:0] {
    PX_NONE  = 3'd0,
    PX_LEAD  = 3'd1,
    PX_BLACK = 3'd2,
    PX_EFF   = 3'd3,
    PX_TRAIL = 3'd4
  } px_class_e;

  typedef enum logic [1:0] {
    SQ_START,
    SQ_GATE,
    SQ_GAP,
    SQ_RUN
  } seq_state_e;

  function automatic int cycles_for(input int ns, input int sys_ns);
    int q;
    q = (ns + sys_ns - 1) / sys_ns;
    return (q < 1) ? 1 : q;
  endfunction

endpackage

// File: rtl/ccd_cfg_shadow.sv
module ccd_cfg_shadow #(
  parameter int HALF_W   = 8,
  parameter int TIME_W   = 8,
  parameter int LINE_W   = 16,
  parameter int MIN_HALF = 1,
  parameter int MIN_GATE = 12,
  parameter int MIN_GAP  = 4,
  parameter int MIN_LINE = 2088
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [TIME_W-1:0] cfg_gate,
  input  logic [TIME_W-1:0] cfg_gap,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic              cfg_sh,
  output logic [HALF_W-1:0] half_len,
  output logic [TIME_W-1:0] gate_len,
  output logic [TIME_W-1:0] gap_len,
  output logic [LINE_W-1:0] line_len,
  output logic              sh_mode
);

  localparam logic [HALF_W-1:0] HALF_FLOOR = HALF_W'(MIN_HALF);
  localparam logic [TIME_W-1:0] GATE_FLOOR = TIME_W'(MIN_GATE);
  localparam logic [TIME_W-1:0] GAP_FLOOR  = TIME_W'(MIN_GAP);
  localparam logic [LINE_W-1:0] LINE_MIN   = LINE_W'(MIN_LINE);

  logic [HALF_W-1:0] half_d;
  logic [TIME_W-1:0] gate_d, gap_d;
  logic [LINE_W-1:0] line_d;

  always_comb begin
    half_d = (cfg_half < HALF_FLOOR) ? HALF_FLOOR : cfg_half;
    gate_d = (cfg_gate < GATE_FLOOR) ? GATE_FLOOR : cfg_gate;
    gap_d  = (cfg_gap  < GAP_FLOOR)  ? GAP_FLOOR  : cfg_gap;
    line_d = (cfg_line < LINE_MIN)   ? LINE_MIN   : cfg_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_len <= HALF_FLOOR;
      gate_len <= GATE_FLOOR;
      gap_len  <= GAP_FLOOR;
      line_len <= LINE_MIN;
      sh_mode  <= 1'b0;
    end else if (load) begin
      half_len <= half_d;
      gate_len <= gate_d;
      gap_len  <= gap_d;
      line_len <= line_d;
      sh_mode  <= cfg_sh;
    end
  end

endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq
  import ccd_timing_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int TIME_W = 8,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_len,
  input  logic [TIME_W-1:0] gate_len,
  input  logic [TIME_W-1:0] gap_len,
  input  logic [LINE_W-1:0] line_len,
  output logic              load_o,
  output logic              pix_start_o,
  output logic              run_o,
  output logic              ccd_clk_o,
  output logic              ccd_gate_o,
  output logic              strobe_o,
  output logic              line_start_o,
  output logic [LINE_W-1:0] pcnt_o
);

  localparam int CNT_W = (HALF_W > TIME_W) ? HALF_W : TIME_W;

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d, lim;
  logic              pclk_q, pclk_d;
  logic [LINE_W-1:0] pcnt_q, pcnt_d;
  logic              last, line_done;

  // phase length of the current state
  always_comb begin
    case (st_q)
      SQ_GATE: lim = CNT_W'(gate_len);
      SQ_GAP:  lim = CNT_W'(gap_len);
      SQ_RUN:  lim = CNT_W'(half_len);
      default: lim = CNT_W'(1);
    endcase
  end

  assign last      = (tcnt_q + CNT_W'(1)) == lim;
  assign line_done = pcnt_q >= line_len;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    pclk_d = pclk_q;
    pcnt_d = pcnt_q;
    case (st_q)
      SQ_START: begin
        st_d   = SQ_GATE;
        tcnt_d = '0;
      end
      SQ_GATE: begin
        if (last) begin
          st_d   = SQ_GAP;
          tcnt_d = '0;
        end else begin
          tcnt_d = tcnt_q + CNT_W'(1);
        end
      end
      SQ_GAP: begin
        if (last) begin
          st_d   = SQ_RUN;
          tcnt_d = '0;
          pclk_d = 1'b1;
          pcnt_d = LINE_W'(1);
        end else begin
          tcnt_d = tcnt_q + CNT_W'(1);
        end
      end
      default: begin
        if (last) begin
          tcnt_d = '0;
          if (pclk_q) begin
            pclk_d = 1'b0;
          end else if (line_done) begin
            st_d = SQ_GATE;
          end else begin
            pclk_d = 1'b1;
            pcnt_d = pcnt_q + LINE_W'(1);
          end
        end else begin
          tcnt_d = tcnt_q + CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_START;
      tcnt_q <= '0;
      pclk_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      pclk_q <= pclk_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign load_o       = (st_q == SQ_START) ||
                        ((st_q == SQ_RUN) && last && !pclk_q && line_done);
  assign pix_start_o  = pclk_d && !pclk_q;
  assign run_o        = (st_q == SQ_RUN);
  assign ccd_clk_o    = pclk_q;
  assign ccd_gate_o   = (st_q == SQ_GATE);
  assign strobe_o     = (st_q == SQ_RUN) && !pclk_q && last;
  assign line_start_o = (st_q == SQ_GATE) && (tcnt_q == '0);
  assign pcnt_o       = pcnt_q;

endmodule

// File: rtl/ccd_pix_decode.sv
module ccd_pix_decode
  import ccd_timing_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic              run,
  input  logic              sh_mode,
  input  logic              strobe,
  input  logic [LINE_W-1:0] pcnt,
  output px_class_e         pclass,
  output logic [IDX_W-1:0]  idx,
  output logic              last_trail
);

  always_comb begin
    int cnt;
    int lead;
    cnt        = int'(pcnt);
    lead       = LEAD_BASE + (sh_mode ? 1 : 0);
    pclass     = PX_NONE;
    idx        = '0;
    last_trail = 1'b0;
    if (run && cnt > 0) begin
      if (cnt <= lead) begin
        if (cnt >= OB_FIRST + lead - LEAD_BASE && cnt <= OB_LAST + lead - LEAD_BASE)
          pclass = PX_BLACK;
        else
          pclass = PX_LEAD;
      end else if (cnt <= lead + EFF_PIX) begin
        pclass = PX_EFF;
        idx    = IDX_W'(cnt - lead - 1);
      end else if (cnt <= lead + EFF_PIX + TRAIL_PIX) begin
        pclass     = PX_TRAIL;
        last_trail = strobe && (cnt == lead + EFF_PIX + TRAIL_PIX);
      end
    end
  end

endmodule

// File: rtl/ccd_warmup.sv
module ccd_warmup #(
  parameter int PULSES = 22500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_start,
  output logic warm
);

  localparam int WCNT_W = $clog2(PULSES + 1);
  localparam logic [WCNT_W-1:0] WCNT_TOP = WCNT_W'(PULSES);

  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic              wcnt_en;

  assign warm    = (wcnt_q == WCNT_TOP);
  assign wcnt_en = pix_start && !warm;
  assign wcnt_d  = wcnt_q + WCNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (wcnt_en) wcnt_q <= wcnt_d;
  end

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timing_pkg::*;
#(
  parameter int SYS_NS      = 250,
  parameter int HALF_W      = 8,
  parameter int TIME_W      = 8,
  parameter int LINE_W      = 16,
  parameter int WARM_PULSES = 22500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [TIME_W-1:0] cfg_gate,
  input  logic [TIME_W-1:0] cfg_gap,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic              cfg_sh,
  output logic              ccd_clk,
  output logic              ccd_gate,
  output logic              ccd_shsel,
  output logic              adc_strobe,
  output logic [2:0]        pix_class,
  output logic              pix_valid,
  output logic [IDX_W-1:0]  pix_idx,
  output logic              ob_flag,
  output logic              line_start,
  output logic              line_end
);

  localparam int MIN_HALF = cycles_for(CLK_PERIOD_MIN / 2, SYS_NS);
  localparam int MIN_GATE = cycles_for(GATE_MIN_NS, SYS_NS);
  localparam int MIN_GAP  = cycles_for(GAP_MIN_NS, SYS_NS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [HALF_W-1:0] half_len;
  logic [TIME_W-1:0] gate_len, gap_len;
  logic [LINE_W-1:0] line_len;
  logic              sh_mode, load, pix_start, run, strobe, warm, last_trail;
  logic [LINE_W-1:0] pcnt;
  px_class_e         pclass;

  ccd_cfg_shadow #(
    .HALF_W(HALF_W), .TIME_W(TIME_W), .LINE_W(LINE_W),
    .MIN_HALF(MIN_HALF), .MIN_GATE(MIN_GATE), .MIN_GAP(MIN_GAP),
    .MIN_LINE(LINE_FLOOR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .load(load),
    .cfg_half(cfg_half), .cfg_gate(cfg_gate), .cfg_gap(cfg_gap),
    .cfg_line(cfg_line), .cfg_sh(cfg_sh),
    .half_len(half_len), .gate_len(gate_len), .gap_len(gap_len),
    .line_len(line_len), .sh_mode(sh_mode)
  );

  ccd_clk_seq #(
    .HALF_W(HALF_W), .TIME_W(TIME_W), .LINE_W(LINE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .half_len(half_len), .gate_len(gate_len), .gap_len(gap_len),
    .line_len(line_len),
    .load_o(load), .pix_start_o(pix_start), .run_o(run),
    .ccd_clk_o(ccd_clk), .ccd_gate_o(ccd_gate), .strobe_o(strobe),
    .line_start_o(line_start), .pcnt_o(pcnt)
  );

  ccd_pix_decode #(.LINE_W(LINE_W)) u_dec (
    .run(run), .sh_mode(sh_mode), .strobe(strobe), .pcnt(pcnt),
    .pclass(pclass), .idx(pix_idx), .last_trail(last_trail)
  );

  ccd_warmup #(.PULSES(WARM_PULSES)) u_warm (
    .clk(clk), .rst_n(rst_core_n), .pix_start(pix_start), .warm(warm)
  );

  assign ccd_shsel  = sh_mode;
  assign adc_strobe = strobe;
  assign pix_class  = pclass;
  assign pix_valid  = warm && (pclass == PX_EFF);
  assign ob_flag    = warm && (pclass == PX_BLACK);
  assign line_end   = last_trail;

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
  parameter int MIN_GATE = 12,
  parameter int MIN_GAP  = 4,
  parameter int IDX_W    = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ccd_clk,
  input logic             ccd_gate,
  input logic             adc_strobe,
  input logic [2:0]       pix_class,
  input logic             pix_valid,
  input logic [IDX_W-1:0] pix_idx,
  input logic             ob_flag,
  input logic             line_start,
  input logic             line_end
);

  logic [15:0] gate_run, gap_run;
  logic        armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_run <= '0;
      gap_run  <= '0;
      armed    <= 1'b0;
    end else begin
      gate_run <= ccd_gate ? ((gate_run == 16'hFFFF) ? gate_run : gate_run + 16'd1) : 16'd0;
      if (ccd_gate) begin
        armed   <= 1'b1;
        gap_run <= '0;
      end else if (ccd_clk) begin
        armed   <= 1'b0;
      end else if (armed && gap_run != 16'hFFFF) begin
        gap_run <= gap_run + 16'd1;
      end
    end
  end

  a_r3_clk_low_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ccd_gate |-> !ccd_clk);

  a_r3_gate_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ccd_gate) |-> gate_run >= 16'(MIN_GATE));

  a_r3_start_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> ccd_gate);

  a_r4_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ccd_clk) && armed) |-> gap_run >= 16'(MIN_GAP));

  a_r10_strobe_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |-> (!ccd_clk && !ccd_gate));

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |=> !adc_strobe);

  a_r11_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_start && line_end));

  a_r11_end_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> adc_strobe);

  a_r8_black_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(ob_flag && pix_valid));

  a_r9_valid_is_effective: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_class == 3'd3));

  a_r9_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid) && pix_idx != $past(pix_idx))
      |-> pix_idx == $past(pix_idx) + IDX_W'(1));

endmodule

bind ccd_line_timer ccd_line_timer_chk #(
  .MIN_GATE(MIN_GATE), .MIN_GAP(MIN_GAP), .IDX_W(ccd_timing_pkg::IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ccd_clk(ccd_clk), .ccd_gate(ccd_gate),
  .adc_strobe(adc_strobe), .pix_class(pix_class), .pix_valid(pix_valid),
  .pix_idx(pix_idx), .ob_flag(ob_flag), .line_start(line_start),
  .line_end(line_end)
);

// File: tb/sim_ccd_line_timer.sv
module sim_ccd_line_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WARM       = 22500;
  localparam int GATE_FLOOR = 12;
  localparam int GAP_FLOOR  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_half, cfg_gate, cfg_gap;
  logic [15:0] cfg_line;
  logic        cfg_sh;
  logic        ccd_clk, ccd_gate, ccd_shsel, adc_strobe;
  logic [2:0]  pix_class;
  logic        pix_valid, ob_flag, line_start, line_end;
  logic [10:0] pix_idx;

  int     errors = 0;
  int     checks = 0;
  longint gcount = 0;
  bit     early  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_line_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_gate(cfg_gate),
    .cfg_gap(cfg_gap), .cfg_line(cfg_line), .cfg_sh(cfg_sh),
    .ccd_clk(ccd_clk), .ccd_gate(ccd_gate), .ccd_shsel(ccd_shsel),
    .adc_strobe(adc_strobe), .pix_class(pix_class), .pix_valid(pix_valid),
    .pix_idx(pix_idx), .ob_flag(ob_flag), .line_start(line_start),
    .line_end(line_end)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int h, input int g, input int p, input int l, input bit s);
    cfg_half = 8'(h);
    cfg_gate = 8'(g);
    cfg_gap  = 8'(p);
    cfg_line = 16'(l);
    cfg_sh   = s;
  endtask

  // observe one line from its line_start to the next line_start
  task automatic run_line(input int e_edges, input int e_half, input int e_gate,
                          input int e_gap, input bit e_sh, input bit chk_valid);
    int edges = 0, gate_n = 0, gap_n = 0, high_n = 0, strobes = 0;
    int lead_n = 0, black_n = 0, eff_n = 0, trail_n = 0, ob_first = 0;
    int end_edge = 0, end_n = 0, valid_n = 0, obf_n = 0, idx_bad = 0, sh_bad = 0;
    int lead = 32 + (e_sh ? 1 : 0);
    bit prev = 1'b0;
    while (!line_start) @(negedge clk);
    do begin
      if (ccd_gate) gate_n++;
      if (!ccd_gate && !ccd_clk && edges == 0) gap_n++;
      if (ccd_clk && !prev) begin edges++; gcount++; end
      prev = ccd_clk;
      if (ccd_clk) high_n++;
      if (ccd_shsel != e_sh) sh_bad++;
      if ((pix_valid || ob_flag) && gcount < WARM) early = 1'b1;
      if (adc_strobe) begin
        strobes++;
        case (pix_class)
          3'd1: lead_n++;
          3'd2: begin lead_n++; black_n++; if (ob_first == 0) ob_first = edges; end
          3'd3: eff_n++;
          3'd4: trail_n++;
          default: ;
        endcase
        if (pix_valid) begin
          valid_n++;
          if (int'(pix_idx) != edges - lead - 1) idx_bad++;
        end
        if (ob_flag) obf_n++;
      end
      if (line_end) begin end_n++; end_edge = edges; end
      @(negedge clk);
    end while (!line_start);
    chk("R2", "edges per line", edges, e_edges);
    chk("R3", "gate width", gate_n, e_gate);
    chk("R4", "gate-to-clock gap", gap_n, e_gap);
    chk("R1", "high cycles", high_n, longint'(e_edges) * e_half);
    chk("R10", "strobes per line", strobes, e_edges);
    chk(e_sh ? "R7" : "R6", "leading pixels", lead_n, lead);
    chk(e_sh ? "R7" : "R6", "effective pixels", eff_n, 2048);
    chk(e_sh ? "R7" : "R6", "trailing pixels", trail_n, 6);
    chk("R7", "shsel mismatches", sh_bad, 0);
    chk("R8", "black pixels", black_n, 18);
    chk("R8", "first black edge", ob_first, 13 + (e_sh ? 1 : 0));
    chk("R11", "line_end count", end_n, 1);
    chk("R11", "line_end edge", end_edge, lead + 2054);
    chk("R12", "valid before warm-up", early, 0);
    if (chk_valid) begin
      chk("R9", "valid pixels", valid_n, 2048);
      chk("R9", "index mismatches", idx_bad, 0);
      chk("R8", "ob_flag pixels", obf_n, 18);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R13", "ccd_clk in reset", ccd_clk, 0);
    chk("R13", "ccd_gate in reset", ccd_gate, 0);
    chk("R13", "strobe in reset", adc_strobe, 0);
    chk("R13", "valid in reset", pix_valid, 0);
    chk("R13", "markers in reset", {line_start, line_end}, 0);
  endtask

  task automatic t_warmup();
    while (gcount < WARM) run_line(2088, 1, 20, 6, 1'b0, 1'b0);
  endtask

  task automatic t_plain();
    run_line(2088, 1, 20, 6, 1'b0, 1'b1);
  endtask

  task automatic t_sh_mode();
    set_cfg(1, 14, 8, 2088, 1'b1);
    run_line(2088, 1, 20, 6, 1'b0, 1'b1); // R5: running line unchanged
    run_line(2088, 1, 14, 8, 1'b1, 1'b1);
  endtask

  task automatic t_clamp();
    set_cfg(0, 1, 0, 100, 1'b0);
    run_line(2088, 1, 14, 8, 1'b1, 1'b1);
    run_line(2088, 1, GATE_FLOOR, GAP_FLOOR, 1'b0, 1'b1);
  endtask

  task automatic t_slow_long();
    set_cfg(3, 30, 10, 2200, 1'b1);
    run_line(2088, 1, GATE_FLOOR, GAP_FLOOR, 1'b0, 1'b1);
    run_line(2200, 3, 30, 10, 1'b1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    set_cfg(1, 20, 6, 2088, 1'b0);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_warmup();
    t_plain();
    t_sh_mode();
    t_clamp();
    t_slow_long();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule